// File: doc/BRIEF.md
# Flash Status Polling Generator

This block forms the word handed back on every array read of a dual-plane flash controller while an embedded program or erase may be running. For each read it looks at the plane being addressed. If that plane is working, the block puts status bits in place of data: a polarity bit that shows whether the operation has finished, a bit that flips on every read, and a second toggling bit that marks the sector whose erase is suspended. A read from a plane that is not working returns the array word unchanged, so code can run from one plane while the other plane is programmed or erased.

The block also drives the enable of an open-drain ready/busy line. The enable is high, pulling the line low, while any plane runs an internal operation. The plane, sector and operation bookkeeping stays with the controller. This block only turns that state, the last loaded address and data, and the array word into the value the host sees. The read word is combinational from the inputs and from the toggle registers. A read counts as completed at the rising clock edge where `rd_strobe` is high.

Top module: `flash_poll_status`

## Requirements
- R1: After reset the ready/busy enable `rb_pull_low` is 0 and both toggle states are 0, so the first strobed read of a new operation shows bit 6 = 0 and the first strobed read of a suspended sector shows bit 2 = 0.
- R2: While the addressed plane is busy with a program (`plane_prog` = 1) and `rd_addr` equals `prog_addr`, bit 7 of `rd_data` is the inverse of bit 7 of `prog_data`.
- R3: While the addressed plane is busy with an erase (`plane_prog` = 0), bit 7 of `rd_data` is 0 for any address in that plane.
- R4: While the addressed plane is busy, bit 6 of `rd_data` is that plane's toggle state, and each completed strobed read of that plane inverts it.
- R5: While a plane has an erase suspended, a read of that plane whose sector (address bits above `SECT_SHIFT`) equals the plane's field in `susp_sector` has bit 2 set to that plane's suspend toggle state, which inverts on each completed strobed read of that sector.
- R6: A read of a plane that is neither busy nor hitting its suspended sector returns `array_data` unchanged, whatever the other plane is doing.
- R7: `rb_pull_low` is 1 in the cycle after any bit of `plane_busy` is 1 and 0 in the cycle after all are 0. A suspended plane that is not busy does not hold it.
- R8: When an operation ends, reads of that plane return true data at once, and the toggle state returns to 0 at the next clock edge, so the next operation starts with bit 6 = 0.
- R9: A toggle state does not change on a cycle without `rd_strobe`, on a strobe to the other plane, or, for bit 2, on a strobe to another sector.
- R10: Every bit of `rd_data` that carries no status (all bits but 7, 6 and 2, and bit 7 in a program read of an address other than `prog_addr`) equals the matching bit of `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strobe | input | 1 | Read completes at this rising edge |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_plane | input | PLANE_W | Plane of the read address |
| array_data | input | DATA_W | Word read from the array |
| plane_busy | input | NUM_PLANES | Internal program or erase running, per plane |
| plane_prog | input | NUM_PLANES | Running operation is a program (1) or an erase (0) |
| plane_susp | input | NUM_PLANES | An erase is suspended in the plane |
| susp_sector | input | NUM_PLANES*SECT_W | Suspended sector number, one field per plane |
| prog_addr | input | ADDR_W | Last loaded program address |
| prog_data | input | DATA_W | Last loaded program data |
| rd_data | output | DATA_W | Word returned to the host |
| rb_pull_low | output | 1 | Enable of the open-drain ready/busy driver |

## Verification
A wrong toggle register shows up on the very next strobed read of that plane as a bit 6 or bit 2 with the wrong phase. A toggle that fails to clear shows up on the first read of the next operation. Wrong plane selection shows up at once, combinationally, as status bits leaking into reads of the idle plane, or as array data where status is due. A fault in the ready/busy register shows up one clock after `plane_busy` changes. The bench therefore walks every pair of plane states and, in each, reads the programmed address, the suspended sector and an unrelated address with and without a strobe.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  // Status bit positions within the returned word.
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned SUSP_BIT = 2;

  // Per-plane condition used when building the read word.
  typedef struct packed {
    logic busy;
    logic prog;
    logic susp_hit;
    logic tog_main;
    logic tog_susp;
  } sel_state_t;

  // Mask of the bits that never carry status.
  function automatic logic [15:0] plain_mask16();
    logic [15:0] m;
    m = '1;
    m[POLL_BIT] = 1'b0;
    m[TOG_BIT]  = 1'b0;
    m[SUSP_BIT] = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/fsp_sector_match.sv
module fsp_sector_match #(
  parameter int unsigned NUM_PLANES = 2,
  parameter int unsigned PLANE_W    = 1,
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned SECT_SHIFT = 12,
  localparam int unsigned SECT_W    = ADDR_W - SECT_SHIFT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [PLANE_W-1:0]           rd_plane,
  input  logic [NUM_PLANES-1:0]        plane_susp,
  input  logic [NUM_PLANES*SECT_W-1:0] susp_sector,
  output logic [NUM_PLANES-1:0]        plane_sel,
  output logic [NUM_PLANES-1:0]        susp_hit
);

  logic [SECT_W-1:0] rd_sect;

  always_comb begin
    rd_sect = rd_addr[ADDR_W-1:SECT_SHIFT];
  end

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic sect_eq;
    always_comb begin
      plane_sel[p] = (rd_plane == PLANE_W'(p));
      sect_eq      = (rd_sect == susp_sector[p*SECT_W +: SECT_W]);
      susp_hit[p]  = plane_sel[p] & plane_susp[p] & sect_eq;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(plane_sel)) else $error("plane select not one-hot"); // R9

  AST_HIT_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_hit & ~plane_sel) == '0) else $error("suspend hit outside plane"); // R5

endmodule

// File: rtl/fsp_toggle_bank.sv
module fsp_toggle_bank #(
  parameter int unsigned NUM_PLANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PLANES-1:0] active,
  input  logic [NUM_PLANES-1:0] advance,
  output logic [NUM_PLANES-1:0] tog_q
);

  logic [NUM_PLANES-1:0] tog_d;
  logic [NUM_PLANES-1:0] tog_en;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_tog
    // Next state: flip on a counted read, clear while the condition is absent.
    always_comb begin
      tog_en[p] = ~active[p] | advance[p];
      tog_d[p]  = active[p] ? ~tog_q[p] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tog_q[p] <= 1'b0;
      end else if (tog_en[p]) begin
        tog_q[p] <= tog_d[p];
      end
    end

    AST_TOG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (active[p] && advance[p]) |=> (tog_q[p] != $past(tog_q[p])))
      else $error("toggle did not advance"); // R4, R5

    AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active[p] && !advance[p]) |=> $stable(tog_q[p]))
      else $error("toggle moved without a read"); // R9

    AST_TOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !active[p] |=> !tog_q[p])
      else $error("toggle not cleared when idle"); // R8
  end

endmodule

// File: rtl/fsp_status_mux.sv
module fsp_status_mux
  import fsp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_state_t        sel,
  input  logic              addr_hit,
  input  logic              prog_b7,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_word
);

  localparam logic [DATA_W-1:0] PLAIN = DATA_W'(plain_mask16()) |
                                        ~DATA_W'(16'hFFFF) ;

  always_comb begin
    rd_word = array_data;
    if (sel.busy) begin
      if (sel.prog) begin
        if (addr_hit) begin
          rd_word[POLL_BIT] = ~prog_b7;
        end
      end else begin
        rd_word[POLL_BIT] = 1'b0;
      end
      rd_word[TOG_BIT] = sel.tog_main;
    end
    if (sel.susp_hit) begin
      rd_word[SUSP_BIT] = sel.tog_susp;
    end
  end

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.busy && sel.prog && addr_hit) |-> (rd_word[POLL_BIT] != prog_b7))
    else $error("program poll bit wrong"); // R2

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.busy && !sel.prog) |-> !rd_word[POLL_BIT])
    else $error("erase poll bit not zero"); // R3

  AST_PLAIN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_word ^ array_data) & PLAIN) == '0)
    else $error("non-status bit altered"); // R10

endmodule

// File: rtl/fsp_rb_driver.sv
module fsp_rb_driver #(
  parameter int unsigned NUM_PLANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PLANES-1:0] plane_busy,
  output logic                  rb_pull_low
);

  logic any_busy;
  logic rb_d;
  logic rb_q;

  always_comb begin
    any_busy = |plane_busy;
    rb_d     = any_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q <= 1'b0;
    end else begin
      rb_q <= rb_d;
    end
  end

  assign rb_pull_low = rb_q;

  AST_RB_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (rb_pull_low == $past(|plane_busy)))
    else $error("ready/busy enable out of step"); // R7

endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import fsp_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned NUM_PLANES = 2,
  parameter int unsigned SECT_SHIFT = 12,
  localparam int unsigned PLANE_W   = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1,
  localparam int unsigned SECT_W    = ADDR_W - SECT_SHIFT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_strobe,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [PLANE_W-1:0]           rd_plane,
  input  logic [DATA_W-1:0]            array_data,
  input  logic [NUM_PLANES-1:0]        plane_busy,
  input  logic [NUM_PLANES-1:0]        plane_prog,
  input  logic [NUM_PLANES-1:0]        plane_susp,
  input  logic [NUM_PLANES*SECT_W-1:0] susp_sector,
  input  logic [ADDR_W-1:0]            prog_addr,
  input  logic [DATA_W-1:0]            prog_data,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         rb_pull_low
);

  logic [NUM_PLANES-1:0] plane_sel;
  logic [NUM_PLANES-1:0] susp_hit;
  logic [NUM_PLANES-1:0] adv_main;
  logic [NUM_PLANES-1:0] adv_susp;
  logic [NUM_PLANES-1:0] tog_main;
  logic [NUM_PLANES-1:0] tog_susp;
  sel_state_t            sel;
  logic                  addr_hit;

  fsp_sector_match #(
    .NUM_PLANES (NUM_PLANES),
    .PLANE_W    (PLANE_W),
    .ADDR_W     (ADDR_W),
    .SECT_SHIFT (SECT_SHIFT)
  ) i_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_addr     (rd_addr),
    .rd_plane    (rd_plane),
    .plane_susp  (plane_susp),
    .susp_sector (susp_sector),
    .plane_sel   (plane_sel),
    .susp_hit    (susp_hit)
  );

  always_comb begin
    adv_main = {NUM_PLANES{rd_strobe}} & plane_sel & plane_busy;
    adv_susp = {NUM_PLANES{rd_strobe}} & susp_hit;
  end

  fsp_toggle_bank #(.NUM_PLANES(NUM_PLANES)) i_tog_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (plane_busy),
    .advance (adv_main),
    .tog_q   (tog_main)
  );

  fsp_toggle_bank #(.NUM_PLANES(NUM_PLANES)) i_tog_susp (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (plane_susp),
    .advance (adv_susp),
    .tog_q   (tog_susp)
  );

  always_comb begin
    sel.busy     = |(plane_busy & plane_sel);
    sel.prog     = |(plane_prog & plane_sel);
    sel.susp_hit = |susp_hit;
    sel.tog_main = |(tog_main & plane_sel);
    sel.tog_susp = |(tog_susp & susp_hit);
    addr_hit     = (rd_addr == prog_addr);
  end

  fsp_status_mux #(.DATA_W(DATA_W)) i_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .addr_hit   (addr_hit),
    .prog_b7    (prog_data[POLL_BIT]),
    .array_data (array_data),
    .rd_word    (rd_data)
  );

  fsp_rb_driver #(.NUM_PLANES(NUM_PLANES)) i_rb (
    .clk         (clk),
    .rst_n       (rst_n),
    .plane_busy  (plane_busy),
    .rb_pull_low (rb_pull_low)
  );

  AST_IDLE_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(plane_busy & plane_sel)) && !(|susp_hit)) |-> (rd_data == array_data))
    else $error("idle plane read altered"); // R6

endmodule

// File: tb/test_flash_poll_status.sv
module test_flash_poll_status;

  localparam int DW = 16;
  localparam int AW = 20;
  localparam int NP = 2;
  localparam int SS = 12;
  localparam int SW = AW - SS;

  logic          clk;
  logic          rst_n;
  logic          rd_strobe;
  logic [AW-1:0] rd_addr;
  logic          rd_plane;
  logic [DW-1:0] array_data;
  logic [NP-1:0] plane_busy;
  logic [NP-1:0] plane_prog;
  logic [NP-1:0] plane_susp;
  logic [NP*SW-1:0] susp_sector;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic [DW-1:0] rd_data;
  logic          rb_pull_low;

  int checks;
  int fails;
  bit done;
  bit m6 [NP];
  bit m2 [NP];
  int nread;

  flash_poll_status i_flash_poll_status (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .rd_plane(rd_plane), .array_data(array_data), .plane_busy(plane_busy),
    .plane_prog(plane_prog), .plane_susp(plane_susp), .susp_sector(susp_sector),
    .prog_addr(prog_addr), .prog_data(prog_data), .rd_data(rd_data),
    .rb_pull_low(rb_pull_low)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference toggle states derived from R4, R5, R8, R9.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m6[p] = 1'b0; m2[p] = 1'b0; end
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (!plane_busy[p]) m6[p] = 1'b0;
        else if (rd_strobe && rd_plane == p[0]) m6[p] = ~m6[p];
        if (!plane_susp[p]) m2[p] = 1'b0;
        else if (rd_strobe && rd_plane == p[0] &&
                 rd_addr[AW-1:SS] == susp_sector[p*SW +: SW]) m2[p] = ~m2[p];
      end
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(input int p, input logic [AW-1:0] a,
                                             input logic [DW-1:0] arr);
    logic [DW-1:0] w;
    w = arr;
    if (plane_busy[p]) begin
      if (plane_prog[p]) begin
        if (a == prog_addr) w[7] = ~prog_data[7];
      end else begin
        w[7] = 1'b0;
      end
      w[6] = m6[p];
    end
    if (plane_susp[p] && a[AW-1:SS] == susp_sector[p*SW +: SW]) w[2] = m2[p];
    return w;
  endfunction

  task automatic do_read(input int p, input logic [AW-1:0] a, input bit stb);
    logic [DW-1:0] e;
    bit sh;
    @(negedge clk);
    nread++;
    rd_plane   = p[0];
    rd_addr    = a;
    rd_strobe  = stb;
    array_data = 16'hA5C3 ^ DW'(nread * 16'h1357);
    #2;
    e  = exp_word(p, a, array_data);
    sh = plane_susp[p] && (a[AW-1:SS] == susp_sector[p*SW +: SW]);
    check(plane_busy[p] ? (plane_prog[p] ? "R2 bit7" : "R3 bit7") : "R6 bit7",
          DW'(rd_data[7]), DW'(e[7]));
    check(!stb ? "R9 bit6" : (plane_busy[p] ? "R4 bit6" : "R6 bit6"),
          DW'(rd_data[6]), DW'(e[6]));
    check(!stb ? "R9 bit2" : (sh ? "R5 bit2" : "R6 bit2"),
          DW'(rd_data[2]), DW'(e[2]));
    check("R10 plain bits", rd_data & 16'hFF3B, e & 16'hFF3B);
  endtask

  task automatic set_cfg(input int s0, input int s1);
    int st [NP];
    st[0] = s0; st[1] = s1;
    @(negedge clk);
    rd_strobe = 1'b0;
    for (int p = 0; p < NP; p++) begin
      plane_busy[p] = (st[p] == 1) || (st[p] == 2) || (st[p] == 4);
      plane_prog[p] = (st[p] == 1) || (st[p] == 4);
      plane_susp[p] = (st[p] >= 3);
    end
    @(posedge clk);
    #2;
    check("R7 ready/busy", DW'(rb_pull_low), DW'(|plane_busy));
  endtask

  function automatic logic [AW-1:0] susp_addr(input int p);
    return {susp_sector[p*SW +: SW], 12'h0AB};
  endfunction

  initial begin
    checks = 0; fails = 0; done = 0; nread = 0;
    rst_n = 1'b0; rd_strobe = 1'b0; rd_addr = '0; rd_plane = 1'b0;
    array_data = 16'h1234; plane_busy = '0; plane_prog = '0; plane_susp = '0;
    susp_sector = {8'h9A, 8'h21};
    prog_addr = 20'h12345; prog_data = 16'h00F0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset ready/busy", DW'(rb_pull_low), '0);
    check("R1 reset idle read", rd_data, 16'h1234);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first strobed reads after reset start with toggle phase 0.
    plane_busy = 2'b01; plane_prog = 2'b00; plane_susp = 2'b10;
    rd_plane = 1'b0; rd_addr = 20'h7F00F; rd_strobe = 1'b1;
    #2;
    check("R1 first bit6", DW'(rd_data[6]), '0);
    @(negedge clk);
    rd_plane = 1'b1; rd_addr = susp_addr(1);
    #2;
    check("R1 first bit2", DW'(rd_data[2]), '0);
    @(negedge clk);
    rd_strobe = 1'b0; plane_busy = '0; plane_susp = '0;
    @(posedge clk);

    // Sweep every pair of plane states and read patterns.
    for (int s0 = 0; s0 < 5; s0++) begin
      for (int s1 = 0; s1 < 5; s1++) begin
        set_cfg(s0, s1);
        prog_data = (s0 + s1) % 2 == 1 ? 16'h0080 : 16'h7F00;
        for (int p = 0; p < NP; p++) begin
          do_read(p, prog_addr, 1'b0);
          do_read(p, prog_addr, 1'b1);
          do_read(p, prog_addr, 1'b1);
          do_read(p, susp_addr(p), 1'b0);
          do_read(p, susp_addr(p), 1'b1);
          do_read(p, susp_addr(p), 1'b1);
          do_read(p, susp_addr(p), 1'b1);
          do_read(p, 20'h7F00F, 1'b1);
        end
      end
    end

    // R8: end of operation returns true data, next operation restarts at 0.
    set_cfg(1, 0);
    do_read(0, prog_addr, 1'b1);
    @(negedge clk);
    rd_strobe = 1'b0; plane_busy = '0; array_data = 16'hBEEF;
    #2;
    check("R8 true data at end", rd_data, 16'hBEEF);
    @(negedge clk);
    plane_busy = 2'b01; plane_prog = 2'b01;
    #2;
    check("R8 restart bit6", DW'(rd_data[6]), '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule